// File: doc/BRIEF.md
# Cache Victim Selector with Way Lockdown

This block decides which way of a 64-way associative cache takes the next line fill after a miss. Two replacement policies are available and can be swapped on any cycle: a round-robin pointer that steps through the ways, and a pseudo-random choice drawn from a 6-bit linear feedback shift register. A single mode input picks between them.

Software can reserve the bottom of the cache through a lockdown base. Every way whose index is below the base is locked and is never offered as a victim. Both policies keep their choice inside the unlocked range from the base up to way 63. The victim index is combinational, so it is ready in the same cycle that the fill request is raised. Only a round-robin fill moves the pointer. The shift register steps on every clock.

Top module: `victim_sel`

## Requirements
- R1: A clock edge with `rstN` low loads the round-robin pointer with the clamped lockdown base and the shift register with the seed 6'h2B. In the first cycle after reset, random mode with base 0 gives way 43, and round-robin mode gives the base that was present during reset.
- R2: `rrMode` = 1 selects round-robin and `rrMode` = 0 selects pseudo-random. A change of mode reaches `victimWay` in the same cycle, without waiting for a clock edge.
- R3: In round-robin mode the victim is the pointer, or the clamped base if the pointer is below it. A cycle with `fillReq` high sets the pointer to that victim plus one.
- R4: In round-robin mode a fill whose victim is way 63 wraps the pointer to the clamped lockdown base.
- R5: The round-robin pointer holds its value on every cycle without `fillReq`, and on every cycle in random mode.
- R6: The shift register advances on every clock, whatever the mode and `fillReq`, as next = {s[4:0], s[5]^s[4]}. In random mode the victim is the register value when that value is at least the clamped base, and the base otherwise.
- R7: `victimWay` is never below the clamped lockdown base, in either mode.
- R8: `lockBase` is 7 bits wide. Any value of 63 or more is treated as 63, and `victimWay` is then 63 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rrMode | input | 1 | 1 = round-robin, 0 = pseudo-random |
| lockBase | input | 7 | Lowest unlocked way; values of 63 or more clamp to 63 |
| fillReq | input | 1 | Line fill request on a miss |
| victimWay | output | 6 | Way chosen for the fill |

## Verification
The step, wrap and hold properties assume that `lockBase` is the same in two consecutive cycles and that the mode is round-robin in both. The shift-register step property only relates cycles in which the base is zero and random mode holds throughout. The stimulus changes base and mode only at the boundaries between test phases, so these properties are active across long runs of fills and idle cycles. The short transition cycles are covered by the combinational floor and clamp properties, and by the scoreboard.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic advRr;    // step the round-robin pointer this cycle
    logic wrapRr;   // the step wraps back to the base
    logic pickRnd;  // output the pseudo-random candidate
  } vsStrobe_t;

  // Feedback taps of a maximal-length Fibonacci LFSR, bit i = stage i+1
  function automatic logic [7:0] lfsrTapMask(input int unsigned width);
    case (width)
      2:       lfsrTapMask = 8'b0000_0011;
      3:       lfsrTapMask = 8'b0000_0110;
      4:       lfsrTapMask = 8'b0000_1100;
      5:       lfsrTapMask = 8'b0001_0100;
      6:       lfsrTapMask = 8'b0011_0000;
      7:       lfsrTapMask = 8'b0110_0000;
      default: lfsrTapMask = 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/victim_sel_lfsr.sv
module victim_sel_lfsr
  import victim_sel_pkg::*;
#(
  parameter int unsigned W    = 6,
  parameter int unsigned SEED = 'h2B
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS     = W'(lfsrTapMask(W));
  localparam logic [W-1:0] SEED_VAL = W'(SEED);

  logic feedback;

  always_comb feedback = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED_VAL;
    else       state <= {state[W-2:0], feedback};
  end
endmodule

// File: rtl/victim_sel_ctrl.sv
module victim_sel_ctrl
  import victim_sel_pkg::*;
(
  input  logic      rrMode,
  input  logic      fillReq,
  input  logic      rrAtTop,
  output vsStrobe_t strb
);
  always_comb begin
    strb.pickRnd = ~rrMode;
    strb.advRr   = rrMode & fillReq;
    strb.wrapRr  = rrMode & fillReq & rrAtTop;
  end
endmodule

// File: rtl/victim_sel_dp.sv
module victim_sel_dp
  import victim_sel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 64,
  parameter int unsigned SEED     = 'h2B,
  parameter int unsigned WAY_W    = $clog2(NUM_WAYS),
  parameter int unsigned BASE_W   = WAY_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] lockBase,
  input  vsStrobe_t         strb,
  output logic              rrAtTop,
  output logic [WAY_W-1:0]  victimWay
);
  localparam logic [WAY_W-1:0]  TOP_WAY  = WAY_W'(NUM_WAYS - 1);
  localparam logic [BASE_W-1:0] TOP_BASE = BASE_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] effBase;
  logic [WAY_W-1:0] rrPtr;
  logic [WAY_W-1:0] rrCand;
  logic [WAY_W-1:0] rndCand;
  logic [WAY_W-1:0] lfsrVal;

  // Clamp the base into the way range
  always_comb begin
    if (lockBase > TOP_BASE) effBase = TOP_WAY;
    else                     effBase = lockBase[WAY_W-1:0];
  end

  victim_sel_lfsr #(.W(WAY_W), .SEED(SEED)) uLfsr (
    .clk   (clk),
    .rstN  (rstN),
    .state (lfsrVal)
  );

  // The floor keeps both candidates out of the locked ways
  always_comb begin
    rrCand  = (rrPtr   < effBase) ? effBase : rrPtr;
    rndCand = (lfsrVal < effBase) ? effBase : lfsrVal;
    rrAtTop = (rrCand == TOP_WAY);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rrPtr <= effBase;
    else if (strb.wrapRr)    rrPtr <= effBase;
    else if (strb.advRr)     rrPtr <= rrCand + WAY_W'(1);
  end

  always_comb victimWay = strb.pickRnd ? rndCand : rrCand;
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_sel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 64,
  parameter int unsigned SEED     = 'h2B,
  parameter int unsigned WAY_W    = $clog2(NUM_WAYS),
  parameter int unsigned BASE_W   = WAY_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrMode,
  input  logic [BASE_W-1:0] lockBase,
  input  logic              fillReq,
  output logic [WAY_W-1:0]  victimWay
);
  vsStrobe_t strb;
  logic      rrAtTop;

  victim_sel_ctrl uCtrl (
    .rrMode  (rrMode),
    .fillReq (fillReq),
    .rrAtTop (rrAtTop),
    .strb    (strb)
  );

  victim_sel_dp #(.NUM_WAYS(NUM_WAYS), .SEED(SEED)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .lockBase  (lockBase),
    .strb      (strb),
    .rrAtTop   (rrAtTop),
    .victimWay (victimWay)
  );
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk
  import victim_sel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 64,
  parameter int unsigned WAY_W    = $clog2(NUM_WAYS),
  parameter int unsigned BASE_W   = WAY_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rrMode,
  input logic [BASE_W-1:0] lockBase,
  input logic              fillReq,
  input logic [WAY_W-1:0]  victimWay
);
  localparam logic [WAY_W-1:0]  TOP_WAY  = WAY_W'(NUM_WAYS - 1);
  localparam logic [BASE_W-1:0] TOP_BASE = BASE_W'(NUM_WAYS - 1);
  localparam logic [WAY_W-1:0]  TAPS     = WAY_W'(lfsrTapMask(WAY_W));

  logic [WAY_W-1:0] chkBase;
  logic             pastOk;

  always_comb chkBase = (lockBase > TOP_BASE) ? TOP_WAY : lockBase[WAY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r7_never_locked: assert property (@(posedge clk) disable iff (!rstN)
    victimWay >= chkBase);

  a_r8_clamp_top: assert property (@(posedge clk) disable iff (!rstN)
    (lockBase >= TOP_BASE) |-> (victimWay == TOP_WAY));

  a_r3_rr_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rrMode && $past(rrMode && fillReq) && $stable(lockBase)
     && ($past(victimWay) != TOP_WAY))
    |-> (victimWay == $past(victimWay) + WAY_W'(1)));

  a_r4_rr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rrMode && $past(rrMode && fillReq) && $stable(lockBase)
     && ($past(victimWay) == TOP_WAY))
    |-> (victimWay == chkBase));

  a_r5_rr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rrMode && $past(rrMode && !fillReq) && $stable(lockBase))
    |-> $stable(victimWay));

  a_r6_lfsr_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !rrMode && $past(!rrMode) && (lockBase == '0) && ($past(lockBase) == '0))
    |-> (victimWay == {$past(victimWay[WAY_W-2:0]), ^($past(victimWay) & TAPS)}));
endmodule

bind victim_sel victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/sim_victim_sel.sv
`timescale 1ns/1ps
module sim_victim_sel;
  logic       clk = 1'b0;
  logic       rstN;
  logic       rrMode;
  logic [6:0] lockBase;
  logic       fillReq;
  logic [5:0] victimWay;

  typedef struct {
    logic [5:0] expWay;
    logic [5:0] floorWay;
    string      tag;
  } item_t;

  item_t queueQ[$];
  int    testsRun  = 0;
  int    testsFail = 0;
  bit    allDone   = 1'b0;

  // Bench model state
  logic [5:0] mRr;
  logic [5:0] mLfsr;

  always #2.5 clk = ~clk;

  victim_sel u0 (
    .clk       (clk),
    .rstN      (rstN),
    .rrMode    (rrMode),
    .lockBase  (lockBase),
    .fillReq   (fillReq),
    .victimWay (victimWay)
  );

  // Driver: one call is one cycle, started at a falling edge
  task automatic cyc(input bit mode, input int base, input bit req, input string tag);
    item_t it;
    logic [5:0] eb;
    logic [5:0] e;
    eb = (base >= 63) ? 6'd63 : 6'(base);
    rrMode   = mode;
    lockBase = 7'(base);
    fillReq  = req;
    if (mode) begin
      e = (mRr < eb) ? eb : mRr;
      if (req) mRr = (e == 6'd63) ? eb : e + 6'd1;
    end else begin
      e = (mLfsr < eb) ? eb : mLfsr;
    end
    mLfsr = {mLfsr[4:0], mLfsr[5] ^ mLfsr[4]};
    it.expWay = e; it.floorWay = eb; it.tag = tag;
    queueQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares one result per cycle, after inputs settle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (queueQ.size() > 0) begin
        it = queueQ.pop_front();
        testsRun++;
        if (victimWay !== it.expWay) begin
          testsFail++;
          $display("FAIL %s: victimWay=%0d expected=%0d", it.tag, victimWay, it.expWay);
        end
        testsRun++;
        if (victimWay < it.floorWay) begin
          testsFail++;
          $display("FAIL R7: victimWay=%0d expected>=%0d", victimWay, it.floorWay);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!allDone) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rrMode = 1'b1; lockBase = 7'd5; fillReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN  = 1'b1;
    mRr   = 6'd5;
    mLfsr = 6'h2B;

    // R1: seed shows in random mode; pointer loaded with the base
    cyc(0, 0, 0, "R1");
    cyc(1, 5, 0, "R1");

    // R3 / R4: round-robin run with base 0, crossing way 63
    for (int i = 0; i < 70; i++)
      cyc(1, 0, 1, (mRr == 6'd63) ? "R4" : "R3");

    // R5: idle cycles hold the pointer
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R5");

    // R2: switch to random mid-stream and back; R5: pointer unchanged
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R2");
    cyc(1, 0, 0, "R2");
    cyc(1, 0, 0, "R5");

    // R3 / R4: base raised above the pointer, wrap lands on base 50
    for (int i = 0; i < 20; i++)
      cyc(1, 50, 1, (mRr == 6'd63) ? "R4" : "R3");

    // R8: clamped base in both modes
    for (int i = 0; i < 4; i++) cyc(1, 100, 1, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 127, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 63, 1, "R8");

    // R6: random mode with a floor, fill requests toggling
    for (int i = 0; i < 200; i++) cyc(0, 40, i[0], "R6");
    // R6: random mode without lockdown
    for (int i = 0; i < 300; i++) cyc(0, 0, i[1], "R6");

    // R2: alternate the mode every cycle
    for (int i = 0; i < 20; i++) cyc(i[0], 10, 1, "R2");

    fillReq = 1'b0;
    repeat (2) @(negedge clk);
    allDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule